// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a small core. The core is word-addressed and 16 bits wide. On every rising clock edge the counter takes the value chosen from four sources. The first is the sequential successor. The second is a conditional branch relative to the incremented counter. The third is a jump that keeps the top bits of the incremented counter and fills the low bits from a long immediate. The fourth is a register-indirect jump. The block also exports the incremented counter so that the core can write it back as a return address.

Instruction decode and the register file sit outside the block. The decoder drives one control pin per kind of transfer. The register file supplies the source register value and a flag that says whether the two compared operands are equal. The block has no data stream, so every pin is a plain level sampled at the clock edge and no valid/ready handshake applies. A synchronous reset returns the counter to address zero.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` becomes 0 on that edge. This holds whatever the control inputs are.
- R2: With no control asserted, `next_pc` equals `pc_q + 1`. On each rising edge without reset, `pc_q` loads the value that `next_pc` held before the edge.
- R3: `link_pc` always equals `pc_q + 1` modulo 2^16. When `pc_q` is 0xFFFF, `link_pc` is 0x0000.
- R4: When `br_eq` is high and `regs_equal` is high, `next_pc` is `link_pc` plus `imm_short` sign-extended from bit 5. This covers negative offsets, and an offset of -1 (6'h3F) targets the branch itself.
- R5: When `br_ne` is high and `regs_equal` is low, `next_pc` is `link_pc` plus the sign-extended `imm_short`.
- R6: A branch whose condition is false gives `next_pc == link_pc`.
- R7: When `jmp` is high and `jmp_reg` is low, `next_pc` is `{link_pc[15:12], imm_long}`.
- R8: When `jmp_reg` is high, `next_pc` equals `rs_val` in full.
- R9: The sources rank as follows: `jmp_reg` over `jmp`, `jmp` over a taken branch, and a taken branch over the sequential value.
- R10: Branch target sums wrap modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imm_short | input | 6 | Signed branch offset in words |
| imm_long | input | 12 | Jump field placed in the low address bits |
| rs_val | input | 16 | Source register value for register jumps |
| regs_equal | input | 1 | High when the compared registers hold equal values |
| br_eq | input | 1 | Branch when equal |
| br_ne | input | 1 | Branch when not equal |
| jmp | input | 1 | Direct jump (also used for jump-and-link) |
| jmp_reg | input | 1 | Jump to register value |
| pc_q | output | 16 | Current program counter |
| next_pc | output | 16 | Value the counter loads on the next edge |
| link_pc | output | 16 | Incremented counter, used as the return address |

## Verification
The properties assume the decoder raises at most one transfer control per cycle. Where two controls overlap, only the priority properties make a claim. The properties also assume that `regs_equal` reflects the operand comparison for the same cycle, which the block cannot check itself. The stimulus table raises a single control in most rows. Two rows combine controls on purpose to test the ranking, and the directed reset case asserts a register jump while reset is high.

// File: rtl/npc_pkg.sv
package npc_pkg;
  // Which source feeds the program counter this cycle.
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2,
    SRC_REG    = 2'd3
  } npc_src_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] pc_plus1
);
  // Word addressing: one step per instruction, wrapping at the top.
  assign pc_plus1 = pc + AW'(1);
endmodule

// File: rtl/npc_branch.sv
module npc_branch #(
  parameter int AW = 16,
  parameter int SW = 6
) (
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] offset,
  input  logic          same,
  input  logic          on_eq,
  input  logic          on_ne,
  output logic          taken,
  output logic [AW-1:0] target
);
  localparam int EXT_W = AW - SW;
  logic [AW-1:0] offset_ext;

  assign offset_ext = {{EXT_W{offset[SW-1]}}, offset};
  assign target     = base + offset_ext;
  assign taken      = (on_eq & same) | (on_ne & ~same);
endmodule

// File: rtl/npc_jump.sv
module npc_jump #(
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] field,
  output logic [AW-1:0] target
);
  localparam int KEEP_W = AW - LW;
  // The upper region bits come from the already incremented counter.
  assign target = {base[AW-1 -: KEEP_W], field};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          use_reg,
  input  logic          use_jump,
  input  logic          use_branch,
  input  logic [AW-1:0] seq_addr,
  input  logic [AW-1:0] branch_addr,
  input  logic [AW-1:0] jump_addr,
  input  logic [AW-1:0] reg_addr,
  output logic [AW-1:0] chosen
);
  npc_src_e src;

  always_comb begin
    if (use_reg)         src = SRC_REG;
    else if (use_jump)   src = SRC_JUMP;
    else if (use_branch) src = SRC_BRANCH;
    else                 src = SRC_SEQ;
  end

  always_comb begin
    case (src)
      SRC_REG:    chosen = reg_addr;
      SRC_JUMP:   chosen = jump_addr;
      SRC_BRANCH: chosen = branch_addr;
      default:    chosen = seq_addr;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int AW = 16,
  parameter int SW = 6,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] imm_short,
  input  logic [LW-1:0] imm_long,
  input  logic [AW-1:0] rs_val,
  input  logic          regs_equal,
  input  logic          br_eq,
  input  logic          br_ne,
  input  logic          jmp,
  input  logic          jmp_reg,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] link_pc
);
  logic [AW-1:0] br_target;
  logic [AW-1:0] jp_target;
  logic          br_taken;

  npc_incr #(.AW(AW)) u_incr (
    .pc       (pc_q),
    .pc_plus1 (link_pc)
  );

  npc_branch #(.AW(AW), .SW(SW)) u_branch (
    .base   (link_pc),
    .offset (imm_short),
    .same   (regs_equal),
    .on_eq  (br_eq),
    .on_ne  (br_ne),
    .taken  (br_taken),
    .target (br_target)
  );

  npc_jump #(.AW(AW), .LW(LW)) u_jump (
    .base   (link_pc),
    .field  (imm_long),
    .target (jp_target)
  );

  npc_select #(.AW(AW)) u_select (
    .use_reg     (jmp_reg),
    .use_jump    (jmp),
    .use_branch  (br_taken),
    .seq_addr    (link_pc),
    .branch_addr (br_target),
    .jump_addr   (jp_target),
    .reg_addr    (rs_val),
    .chosen      (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int AW = 16,
  parameter int SW = 6,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] imm_short,
  input logic [LW-1:0] imm_long,
  input logic [AW-1:0] rs_val,
  input logic          regs_equal,
  input logic          br_eq,
  input logic          br_ne,
  input logic          jmp,
  input logic          jmp_reg,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] link_pc
);
  localparam int EXT_W = AW - SW;
  localparam int KEEP_W = AW - LW;
  logic [AW-1:0] off_ext;
  logic          past_valid;

  assign off_ext = {{EXT_W{imm_short[SW-1]}}, imm_short};

  always_ff @(posedge clk) past_valid <= 1'b1;

  // R1: the first cycle after reset starts at address zero
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $past(rst)) |-> (pc_q == '0));

  // R2: the counter follows the selected value
  p_pc_follows_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc_q == $past(next_pc)));

  // R2: with no control raised, the sequential value is chosen
  p_seq_default_r2: assert property (@(posedge clk) disable iff (rst)
    (!br_eq && !br_ne && !jmp && !jmp_reg) |-> (next_pc == link_pc));

  // R4: a taken equal-branch lands at the offset target
  p_beq_target_r4: assert property (@(posedge clk) disable iff (rst)
    (br_eq && regs_equal && !jmp && !jmp_reg) |-> (next_pc == link_pc + off_ext));

  // R5: a taken not-equal branch lands at the offset target
  p_bne_target_r5: assert property (@(posedge clk) disable iff (rst)
    (br_ne && !regs_equal && !jmp && !jmp_reg) |-> (next_pc == link_pc + off_ext));

  // R6: a false condition keeps sequential flow
  p_not_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !jmp_reg && !(br_eq && regs_equal) && !(br_ne && !regs_equal))
      |-> (next_pc == link_pc));

  // R7: a direct jump keeps the region bits and takes the field
  p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
    (jmp && !jmp_reg) |-> (next_pc[LW-1:0] == imm_long &&
                           next_pc[AW-1 -: KEEP_W] == link_pc[AW-1 -: KEEP_W]));

  // R8, R9: the register jump overrides every other source
  p_reg_jump_r8: assert property (@(posedge clk) disable iff (rst)
    jmp_reg |-> (next_pc == rs_val));
endmodule

bind npc_unit npc_unit_chk #(.AW(AW), .SW(SW), .LW(LW)) u_npc_chk (
  .clk        (clk),
  .rst        (rst),
  .imm_short  (imm_short),
  .imm_long   (imm_long),
  .rs_val     (rs_val),
  .regs_equal (regs_equal),
  .br_eq      (br_eq),
  .br_ne      (br_ne),
  .jmp        (jmp),
  .jmp_reg    (jmp_reg),
  .pc_q       (pc_q),
  .next_pc    (next_pc),
  .link_pc    (link_pc)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  imm_short;
  logic [11:0] imm_long;
  logic [15:0] rs_val;
  logic        regs_equal, br_eq, br_ne, jmp, jmp_reg;
  logic [15:0] pc_q, next_pc, link_pc;

  int applied = 0;
  int miscmp  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .imm_short(imm_short), .imm_long(imm_long),
    .rs_val(rs_val), .regs_equal(regs_equal), .br_eq(br_eq), .br_ne(br_ne),
    .jmp(jmp), .jmp_reg(jmp_reg), .pc_q(pc_q), .next_pc(next_pc), .link_pc(link_pc)
  );

  // Row: {jmp_reg,jmp,br_ne,br_eq}, regs_equal, imm_short, imm_long, rs_val,
  //      expected next_pc, expected link_pc, requirement number
  localparam logic [74:0] VEC [NVEC] = '{
    {4'b0000, 1'b0, 6'h00, 12'h000, 16'h0000, 16'h0001, 16'h0001, 4'd2},  // R2 pc=0
    {4'b0000, 1'b0, 6'h00, 12'h000, 16'h0000, 16'h0002, 16'h0002, 4'd2},  // R2 pc=1
    {4'b0001, 1'b1, 6'h03, 12'h000, 16'h0000, 16'h0006, 16'h0003, 4'd4},  // R4 forward
    {4'b0001, 1'b0, 6'h03, 12'h000, 16'h0000, 16'h0007, 16'h0007, 4'd6},  // R6 beq false
    {4'b0010, 1'b0, 6'h3E, 12'h000, 16'h0000, 16'h0006, 16'h0008, 4'd5},  // R5 backward
    {4'b0010, 1'b1, 6'h05, 12'h000, 16'h0000, 16'h0007, 16'h0007, 4'd6},  // R6 bne false
    {4'b0001, 1'b1, 6'h3F, 12'h000, 16'h0000, 16'h0007, 16'h0008, 4'd4},  // R4 self loop
    {4'b0100, 1'b0, 6'h00, 12'hABC, 16'h0000, 16'h0ABC, 16'h0008, 4'd7},  // R7
    {4'b1000, 1'b0, 6'h00, 12'h000, 16'h1234, 16'h1234, 16'h0ABD, 4'd8},  // R8
    {4'b0100, 1'b0, 6'h00, 12'h055, 16'h0000, 16'h1055, 16'h1235, 4'd7},  // R7 region kept
    {4'b1100, 1'b0, 6'h00, 12'h111, 16'hFFFF, 16'hFFFF, 16'h1056, 4'd9},  // R9 reg over jump
    {4'b0000, 1'b0, 6'h00, 12'h000, 16'h0000, 16'h0000, 16'h0000, 4'd3},  // R3 wrap
    {4'b1000, 1'b0, 6'h00, 12'h000, 16'hFFFE, 16'hFFFE, 16'h0001, 4'd8},  // R8
    {4'b0101, 1'b1, 6'h05, 12'h321, 16'h0000, 16'hF321, 16'hFFFF, 4'd9},  // R9 jump over branch
    {4'b1000, 1'b0, 6'h00, 12'h000, 16'hFFFD, 16'hFFFD, 16'hF322, 4'd8},  // R8
    {4'b0001, 1'b1, 6'h04, 12'h000, 16'h0000, 16'h0002, 16'hFFFE, 4'd10}, // R10 wrap up
    {4'b0010, 1'b0, 6'h20, 12'h000, 16'h0000, 16'hFFE3, 16'h0003, 4'd10}, // R10 wrap down
    {4'b0100, 1'b0, 6'h00, 12'h000, 16'h0000, 16'hF000, 16'hFFE4, 4'd7},  // R7 zero field
    {4'b0001, 1'b1, 6'h1F, 12'h000, 16'h0000, 16'hF020, 16'hF001, 4'd4}   // R4 max positive
  };

  task automatic check(input string what, input int req, input logic [15:0] act,
                       input logic [15:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic eq, input logic [5:0] s,
                       input logic [11:0] l, input logic [15:0] r);
    {jmp_reg, jmp, br_ne, br_eq} = c;
    regs_equal = eq; imm_short = s; imm_long = l; rs_val = r;
  endtask

  initial begin
    rst = 1'b1;
    drive(4'b0000, 1'b0, 6'h00, 12'h000, 16'h0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("pc after reset", 1, pc_q, 16'h0000);   // R1
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [74:0] v;
      v = VEC[i];
      drive(v[74:71], v[70], v[69:64], v[63:52], v[51:36]);
      #1;
      check("next_pc", int'(v[3:0]), next_pc, v[35:20]);
      check("link_pc", 3, link_pc, v[19:4]);       // R3
      @(posedge clk);
      @(negedge clk);
      check("pc loads next_pc", 2, pc_q, v[35:20]); // R2
    end

    // R9: register jump beats a taken branch; pc is 0xF020 here
    drive(4'b1001, 1'b1, 6'h02, 12'h000, 16'h4242);
    #1;
    check("reg jump over branch", 9, next_pc, 16'h4242);
    @(posedge clk); @(negedge clk);
    check("pc after reg jump", 8, pc_q, 16'h4242);

    // R1: reset wins over a register jump mid-run
    rst = 1'b1;
    drive(4'b1000, 1'b0, 6'h00, 12'h000, 16'h5555);
    @(posedge clk); @(negedge clk);
    check("pc reset mid-run", 1, pc_q, 16'h0000);
    rst = 1'b0;
    drive(4'b0000, 1'b0, 6'h00, 12'h000, 16'h0000);
    #1;
    check("sequential after reset", 2, next_pc, 16'h0001);
    @(posedge clk); @(negedge clk);
    check("pc steps after reset", 2, pc_q, 16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end
endmodule